// File: doc/BRIEF.md
# Credit-Based Transmit Admission Gate

This block sits on the transmit side of a point-to-point link that uses credit-based flow control. The far receiver advertises how much buffer space it has for two credit classes: packet headers and packet payload data. The gate loads these two advertised amounts as its starting limits. It then decides, in the same cycle a packet asks to go, whether sending that packet keeps the credits used in both classes inside the current limits. Each time a packet is granted, its header and data costs are added to the used-credit counters. When the receiver drains its buffers it returns credits, and the gate raises the matching limit by the returned amount.

The used and limit counters are never cleared during operation and wrap freely. For that reason the grant test is a modular window comparison and not a count-down to zero. A class whose advertised amount is zero is treated as unlimited. A credit return and a grant in the same cycle both take effect, so the round-trip time of returned credits costs no throughput as long as the limit is not reached.

Top module: `fc_admit_gate`

## Requirements
- R1: After reset `grant` stays low for every request until an initial credit load has been accepted; a reset in mid-operation returns the gate to this unloaded state.
- R2: A cycle with `init_vld` high sets each class limit to its advertised value (`init_hdr`, `init_dat`) and clears both used counters.
- R3: `grant` is high in the same cycle as `req_vld` only when both the header class and the data class pass their test; with `req_vld` low, `grant` is low.
- R4: A class passes when (limit − (used + cost)) taken modulo 2^CW (256 by default) is at most 2^(CW−1) (128 by default); a result of 128 passes and 129 fails.
- R5: On a granted cycle each used counter advances by that class's request cost, modulo 2^CW.
- R6: When `ret_vld` is high after a load, each class limit rises by its returned amount (`ret_hdr`, `ret_dat`), modulo 2^CW.
- R7: A return and a grant in the same cycle both update their counters at the same clock edge.
- R8: An advertised value of zero makes that class unlimited: it passes every cost until the next load.
- R9: The grant test stays correct when the used and limit counters wrap past 255 back to 0.
- R10: A request that is not granted, and a cycle with no request, return or load, leave every counter unchanged.
- R11: In a cycle with `init_vld` high, `grant` is low, and any return in that cycle is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| init_vld | input | 1 | Load advertised initial credits for both classes |
| init_hdr | input | CW | Advertised header credits (0 = unlimited) |
| init_dat | input | CW | Advertised data credits (0 = unlimited) |
| ret_vld | input | 1 | Receiver credit return strobe |
| ret_hdr | input | CW | Header credits returned |
| ret_dat | input | CW | Data credits returned |
| req_vld | input | 1 | A packet asks to be sent this cycle |
| req_hdr | input | CW | Header credit cost of the packet |
| req_dat | input | CW | Data credit cost of the packet |
| grant | output | 1 | Packet may be sent; costs are charged at the next edge |

## Verification
The hardest situation to reach is a grant decision made while the used and limit counters sit on opposite sides of the 255-to-0 wrap. The stimulus gets there with alternating large returns and large packet costs on the data class, so the limit wraps first and the used count follows it. It then probes costs one credit below, exactly at, and one above the remaining window. The 128-credit window edge is handled the same way: the bench loads a limit of 130 and asks for costs that leave 129 and then 128.

// File: rtl/fc_admit_pkg.sv
package fc_admit_pkg;
   // credit classes tracked by the gate
   typedef enum int unsigned {
      CLS_HDR = 0,
      CLS_DAT = 1
   } cls_e;
   localparam int unsigned NCLS = 2;

   // width-generic window rule: remaining credit after the packet must
   // fall in the lower half of the modular range
   function automatic logic window_ok(input int unsigned cw,
                                      input logic [31:0] remain);
      logic [31:0] mask;
      logic [31:0] half;
      mask = (32'd1 << cw) - 32'd1;
      half = 32'd1 << (cw - 1);
      return ((remain & mask) <= half);
   endfunction
endpackage

// File: rtl/fc_window_cmp.sv
module fc_window_cmp #(
   parameter int unsigned CW = 8
) (
   input  logic [CW-1:0] lim,
   input  logic [CW-1:0] used,
   input  logic [CW-1:0] cost,
   input  logic          unlimited,
   output logic          ok
);
   import fc_admit_pkg::*;

   logic [CW-1:0] after_use;
   logic [CW-1:0] remain;

   always_comb begin
      after_use = used + cost;
      remain    = lim - after_use;
      ok        = unlimited | window_ok(CW, 32'(remain));
   end
endmodule

// File: rtl/fc_class_tracker.sv
module fc_class_tracker #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] adv,
   input  logic          ret_en,
   input  logic [CW-1:0] ret_amt,
   input  logic          take,
   input  logic [CW-1:0] cost,
   output logic          pass,
   output logic [CW-1:0] lim_o,
   output logic [CW-1:0] used_o
);
   logic [CW-1:0] lim_q;
   logic [CW-1:0] used_q;
   logic          unl_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lim_q  <= '0;
         used_q <= '0;
         unl_q  <= 1'b0;
      end else if (load) begin
         lim_q  <= adv;
         used_q <= '0;
         unl_q  <= (adv == '0);
      end else begin
         if (ret_en) lim_q  <= lim_q + ret_amt;
         if (take)   used_q <= used_q + cost;
      end
   end

   fc_window_cmp #(.CW(CW)) u_cmp (
      .lim       (lim_q),
      .used      (used_q),
      .cost      (cost),
      .unlimited (unl_q),
      .ok        (pass)
   );

   assign lim_o  = lim_q;
   assign used_o = used_q;
endmodule

// File: rtl/fc_admit_gate.sv
module fc_admit_gate #(
   parameter int unsigned CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          init_vld,
   input  logic [CW-1:0] init_hdr,
   input  logic [CW-1:0] init_dat,
   input  logic          ret_vld,
   input  logic [CW-1:0] ret_hdr,
   input  logic [CW-1:0] ret_dat,
   input  logic          req_vld,
   input  logic [CW-1:0] req_hdr,
   input  logic [CW-1:0] req_dat,
   output logic          grant
);
   import fc_admit_pkg::*;

   if (CW < 2 || CW > 31) begin : g_bad_cw
      $error("fc_admit_gate: CW must lie in 2..31");
   end

   logic                      loaded_q;
   logic                      ret_en;
   logic [NCLS-1:0]           cls_pass;
   logic [NCLS-1:0][CW-1:0]   adv_v;
   logic [NCLS-1:0][CW-1:0]   ret_v;
   logic [NCLS-1:0][CW-1:0]   cost_v;
   logic [NCLS-1:0][CW-1:0]   lim_q;
   logic [NCLS-1:0][CW-1:0]   used_q;

   assign adv_v[CLS_HDR]  = init_hdr;
   assign adv_v[CLS_DAT]  = init_dat;
   assign ret_v[CLS_HDR]  = ret_hdr;
   assign ret_v[CLS_DAT]  = ret_dat;
   assign cost_v[CLS_HDR] = req_hdr;
   assign cost_v[CLS_DAT] = req_dat;

   always_ff @(posedge clk) begin
      if (!rst_n)        loaded_q <= 1'b0;
      else if (init_vld) loaded_q <= 1'b1;
   end

   assign ret_en = ret_vld & loaded_q & ~init_vld;
   assign grant  = req_vld & loaded_q & ~init_vld & (&cls_pass);

   for (genvar c = 0; c < NCLS; c++) begin : g_cls
      fc_class_tracker #(.CW(CW)) u_trk (
         .clk     (clk),
         .rst_n   (rst_n),
         .load    (init_vld),
         .adv     (adv_v[c]),
         .ret_en  (ret_en),
         .ret_amt (ret_v[c]),
         .take    (grant),
         .cost    (cost_v[c]),
         .pass    (cls_pass[c]),
         .lim_o   (lim_q[c]),
         .used_o  (used_q[c])
      );
   end
endmodule

// File: rtl/fc_admit_gate_chk.sv
module fc_admit_gate_chk #(
   parameter int unsigned CW = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 init_vld,
   input logic [CW-1:0]        init_hdr,
   input logic [CW-1:0]        init_dat,
   input logic                 ret_vld,
   input logic [CW-1:0]        ret_hdr,
   input logic [CW-1:0]        ret_dat,
   input logic                 req_vld,
   input logic [CW-1:0]        req_hdr,
   input logic [CW-1:0]        req_dat,
   input logic                 grant,
   input logic [1:0][CW-1:0]   lim_q,
   input logic [1:0][CW-1:0]   used_q
);
   logic          seen_init;
   logic          armed;
   logic [CW-1:0] nxt_used_h, nxt_used_d, nxt_lim_h, nxt_lim_d;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_init <= 1'b0;
         armed     <= 1'b0;
      end else begin
         armed <= 1'b1;
         if (init_vld) seen_init <= 1'b1;
      end
   end

   always_comb begin
      nxt_used_h = used_q[0] + req_hdr;
      nxt_used_d = used_q[1] + req_dat;
      nxt_lim_h  = lim_q[0] + ret_hdr;
      nxt_lim_d  = lim_q[1] + ret_dat;
   end

   // R3
   grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> req_vld);

   // R1
   no_grant_unloaded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_init |-> !grant);

   // R11
   load_blocks_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      init_vld |-> !grant);

   // R2
   init_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && init_vld) |=> (lim_q[0] == $past(init_hdr) && lim_q[1] == $past(init_dat)
                               && used_q[0] == '0 && used_q[1] == '0));

   // R5
   consume_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && grant) |=> (used_q[0] == $past(nxt_used_h) && used_q[1] == $past(nxt_used_d)));

   // R6
   return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && ret_vld && seen_init && !init_vld) |=>
         (lim_q[0] == $past(nxt_lim_h) && lim_q[1] == $past(nxt_lim_d)));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !grant && !ret_vld && !init_vld) |=> ($stable(used_q) && $stable(lim_q)));
endmodule

bind fc_admit_gate fc_admit_gate_chk #(.CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .init_vld (init_vld),
   .init_hdr (init_hdr),
   .init_dat (init_dat),
   .ret_vld  (ret_vld),
   .ret_hdr  (ret_hdr),
   .ret_dat  (ret_dat),
   .req_vld  (req_vld),
   .req_hdr  (req_hdr),
   .req_dat  (req_dat),
   .grant    (grant),
   .lim_q    (lim_q),
   .used_q   (used_q)
);

// File: tb/sim_fc_admit_gate.sv
module sim_fc_admit_gate;
   localparam int CW = 8;

   typedef struct packed {
      logic       iv;
      logic [7:0] ih;
      logic [7:0] id;
      logic       rv;
      logic [7:0] rh;
      logic [7:0] rd;
      logic       qv;
      logic [7:0] qh;
      logic [7:0] qd;
      logic       exp;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 32;
   localparam vec_t TBL [NV] = '{
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd1,  8'd1,  1'b0,4'd1},  // R1 no load yet
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b0,8'd0,  8'd0,  1'b0,4'd3},  // R3 idle
      '{1'b1,8'd4,  8'd16,1'b0,8'd0,8'd0,   1'b1,8'd1,  8'd1,  1'b0,4'd11}, // R11 load cycle
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd1,  8'd4,  1'b1,4'd2},  // R2 limits 4/16
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd3,  8'd12, 1'b1,4'd5},  // R5 fills both
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd1,  8'd0,  1'b0,4'd4},  // R4 hdr over
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd0,  8'd1,  1'b0,4'd3},  // R3 data blocks
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd0,  8'd0,  1'b1,4'd4},  // R4 zero cost
      '{1'b0,8'd0,  8'd0, 1'b1,8'd2,8'd8,   1'b1,8'd1,  8'd1,  1'b0,4'd10}, // R10 denied
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd2,  8'd8,  1'b1,4'd6},  // R6 limits 6/24
      '{1'b0,8'd0,  8'd0, 1'b1,8'd3,8'd3,   1'b0,8'd0,  8'd0,  1'b0,4'd6},  // R6 limits 9/27
      '{1'b0,8'd0,  8'd0, 1'b1,8'd1,8'd1,   1'b1,8'd1,  8'd1,  1'b1,4'd7},  // R7 both apply
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd3,  8'd3,  1'b1,4'd7},  // R7 return seen
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd1,  8'd0,  1'b0,4'd7},  // R7 consume seen
      '{1'b0,8'd0,  8'd0, 1'b1,8'd0,8'd120, 1'b0,8'd0,  8'd0,  1'b0,4'd9},  // R9 dlim 148
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd0,  8'd120,1'b1,4'd9},  // R9 dused 148
      '{1'b0,8'd0,  8'd0, 1'b1,8'd0,8'd120, 1'b0,8'd0,  8'd0,  1'b0,4'd9},  // R9 dlim wraps 12
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd0,  8'd100,1'b1,4'd9},  // R9 across wrap
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd0,  8'd21, 1'b0,4'd9},  // R9 one over
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd0,  8'd20, 1'b1,4'd9},  // R9 exact, used wraps
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd0,  8'd1,  1'b0,4'd9},  // R9 full
      '{1'b1,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b0,8'd0,  8'd0,  1'b0,4'd8},  // R8 load unlimited
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd200,8'd250,1'b1,4'd8},  // R8
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd255,8'd255,1'b1,4'd8},  // R8
      '{1'b1,8'd2,  8'd0, 1'b1,8'd9,8'd9,   1'b1,8'd1,  8'd1,  1'b0,4'd11}, // R11 return dropped
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd2,  8'd255,1'b1,4'd8},  // R8 data only unlimited
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd1,  8'd0,  1'b0,4'd11}, // R11 hdr limit 2 kept
      '{1'b1,8'd130,8'd0, 1'b0,8'd0,8'd0,   1'b0,8'd0,  8'd0,  1'b0,4'd2},  // R2 reload
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd1,  8'd0,  1'b0,4'd4},  // R4 remain 129
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd2,  8'd0,  1'b1,4'd4},  // R4 remain 128
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd0,  8'd0,  1'b1,4'd4},  // R4 remain 128 again
      '{1'b0,8'd0,  8'd0, 1'b0,8'd0,8'd0,   1'b1,8'd1,  8'd0,  1'b1,4'd4}   // R4 remain 127
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          init_vld = 1'b0;
   logic [CW-1:0] init_hdr = '0, init_dat = '0;
   logic          ret_vld = 1'b0;
   logic [CW-1:0] ret_hdr = '0, ret_dat = '0;
   logic          req_vld = 1'b0;
   logic [CW-1:0] req_hdr = '0, req_dat = '0;
   logic          grant;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   fc_admit_gate #(.CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n),
      .init_vld(init_vld), .init_hdr(init_hdr), .init_dat(init_dat),
      .ret_vld(ret_vld), .ret_hdr(ret_hdr), .ret_dat(ret_dat),
      .req_vld(req_vld), .req_hdr(req_hdr), .req_dat(req_dat),
      .grant(grant)
   );

   task automatic check_grant(input logic exp, input int rq, input string what);
      checks++;
      if (grant !== exp) begin
         errors++;
         $display("FAIL R%0d %s: grant=%b expected %b", rq, what, grant, exp);
      end
   endtask

   task automatic apply(input vec_t v);
      @(negedge clk);
      init_vld = v.iv; init_hdr = v.ih; init_dat = v.id;
      ret_vld  = v.rv; ret_hdr  = v.rh; ret_dat  = v.rd;
      req_vld  = v.qv; req_hdr  = v.qh; req_dat  = v.qd;
      #2;
   endtask

   initial begin
      vec_t idle;
      idle = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      req_vld = 1'b1; req_hdr = 8'd1; req_dat = 8'd1;
      #2 check_grant(1'b0, 1, "reset state");           // R1

      for (int i = 0; i < NV; i++) begin
         apply(TBL[i]);
         check_grant(TBL[i].exp, int'(TBL[i].rq), $sformatf("vector %0d", i));
      end

      // R1: mid-run reset drops the loaded credits
      apply(idle);
      rst_n = 1'b0;
      req_vld = 1'b1; req_hdr = 8'd0; req_dat = 8'd0;
      @(negedge clk);
      #2 check_grant(1'b0, 1, "in reset");
      rst_n = 1'b1;
      @(negedge clk);
      #2 check_grant(1'b0, 1, "after reset, unloaded");

      // R3: loaded but no request
      apply('{1'b1,8'd5,8'd5,1'b0,8'd0,8'd0,1'b0,8'd0,8'd0,1'b0,4'd3});
      apply('{1'b0,8'd0,8'd0,1'b0,8'd0,8'd0,1'b0,8'd5,8'd5,1'b0,4'd3});
      check_grant(1'b0, 3, "no request");
      apply('{1'b0,8'd0,8'd0,1'b0,8'd0,8'd0,1'b1,8'd5,8'd5,1'b1,4'd3});
      check_grant(1'b1, 3, "exact fit after reload");   // R3, R10

      apply(idle);
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #1000000;
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule